// File: doc/BRIEF.md
# I/O and Memory Address Router

This block sits on a processor's request path and sends every read or write to exactly one of two targets: main memory or the device-register side. A request carries a space flag alongside its address. When the flag selects port space, the request always goes to the devices, and only the low 16 address bits are forwarded. When the flag selects memory space, the full 32-bit address is compared against a small table of windows. Each window has an inclusive base, an inclusive limit and a valid bit. A hit in any valid window sends the request to the devices. Every other address goes to memory. A single router can therefore serve three layouts: separate port and memory spaces, devices mapped into memory, or a mix of the two.

Start-up code fills the window table through a configuration port and then sets a lock. The lock holds the table fixed until the next reset. One request is in flight at a time. The chosen target sees its request held steady until it acknowledges. If the chosen target stays silent for 16 cycles, the router ends the transaction itself with an error and all-ones read data.

Top module: `io_mem_router`

## Requirements
- R1: A request with `req_io`=1 (port space) goes to the device side only. `dev_io`=1 and `dev_addr` = {16'h0, req_addr[15:0]}, whatever the window table holds.
- R2: A request with `req_io`=0 whose address satisfies base <= addr <= limit for any valid window goes to the device side, with `dev_io`=0 and the full 32-bit address.
- R3: A memory-space request that matches no valid window goes to memory, with the full address on `mem_addr`.
- R4: `mem_req` and `dev_req` are never high together, and both are low while no request is outstanding. The request outputs, address, write flag and write data are registered one cycle after acceptance. They then hold steady until the transaction ends.
- R5: A `cfg_we` pulse writes base, limit and valid into entry `cfg_idx` only while the lock is clear. A `cfg_lock` pulse sets the lock, and the lock stays set until reset. Writes made after that point have no effect on routing.
- R6: A window whose valid bit is clear, or whose base is above its limit, matches no address. After reset, all windows are invalid.
- R7: When the selected target's ack is sampled, `resp_valid` is high for exactly one cycle after that edge, with `resp_err`=0 and `resp_rdata` equal to that target's read data. An ack from the target that was not selected is ignored.
- R8: If the selected target gives no ack on the 16 clock edges that follow acceptance, the 16th edge ends the transaction with `resp_valid`=1, `resp_err`=1 and `resp_rdata`=32'hFFFFFFFF. An ack sampled on that 16th edge takes precedence, and the response is a normal one.
- R9: `req_ready` is high exactly when no request is outstanding, including after reset. A `req_valid` presented while `req_ready` is low is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window table write strobe |
| cfg_idx | input | 2 | Window entry to write |
| cfg_base | input | 32 | Inclusive lower bound of the window |
| cfg_limit | input | 32 | Inclusive upper bound of the window |
| cfg_valid | input | 1 | Valid bit for the window |
| cfg_lock | input | 1 | Sets the table lock (sticky until reset) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router idle, request will be accepted |
| req_io | input | 1 | 1 = port space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Completion ended by timeout |
| resp_rdata | output | 32 | Read data or 32'hFFFFFFFF on timeout |
| mem_req | output | 1 | Memory request, held until ack or timeout |
| mem_write | output | 1 | Write flag to memory |
| mem_addr | output | 32 | Address to memory |
| mem_wdata | output | 32 | Write data to memory |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| dev_req | output | 1 | Device request, held until ack or timeout |
| dev_io | output | 1 | Space flag passed to devices |
| dev_write | output | 1 | Write flag to devices |
| dev_addr | output | 32 | Address to devices |
| dev_wdata | output | 32 | Write data to devices |
| dev_ack | input | 1 | Device acknowledge |
| dev_rdata | input | 32 | Device read data, valid with ack |

## Verification
Two events can fall on the same clock edge: the acknowledge from the target and the expiry of the 16-cycle wait. The bench sweeps the ack delay from 1 to 18 cycles for both targets, so an ack lands on edge 15, on edge 16 (the same edge as expiry) and after the window has closed. On edge 16 it expects a normal completion with the target's data. At any later delay it expects the error response with all-ones data, and it counts the response cycle from the bench's own model. The same sweep repeats with the wrong target acknowledging, to show that such an ack cannot end the transaction early.

// File: rtl/iorouter_pkg.sv
package iorouter_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } txn_state_e;

  typedef enum logic {
    TGT_MEM = 1'b0,
    TGT_DEV = 1'b1
  } target_e;
endpackage

// File: rtl/io_window_table.sv
module io_window_table #(
  parameter int NWIN = 4,
  parameter int AW   = 32,
  localparam int IDXW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [AW-1:0]   cfg_base,
  input  logic [AW-1:0]   cfg_limit,
  input  logic            cfg_valid,
  input  logic            cfg_lock,
  input  logic [AW-1:0]   look_addr,
  output logic            look_hit
);
  logic [NWIN-1:0][AW-1:0] base_q;
  logic [NWIN-1:0][AW-1:0] lim_q;
  logic [NWIN-1:0]         vld_q;
  logic                    lock_q;
  logic [NWIN-1:0]         hit_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      lim_q  <= '0;
      vld_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (cfg_lock) lock_q <= 1'b1;
      if (cfg_we && !lock_q) begin
        base_q[cfg_idx] <= cfg_base;
        lim_q[cfg_idx]  <= cfg_limit;
        vld_q[cfg_idx]  <= cfg_valid;
      end
    end
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    assign hit_vec[i] = vld_q[i] && (look_addr >= base_q[i]) && (look_addr <= lim_q[i]);
  end

  assign look_hit = |hit_vec;

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);

  // R5
  table_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(vld_q) && $stable(base_q) && $stable(lim_q)));
endmodule

// File: rtl/io_ack_timer.sv
module io_ack_timer #(
  parameter int LIMIT = 16,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(LIMIT));
endmodule

// File: rtl/io_txn_ctrl.sv
module io_txn_ctrl
  import iorouter_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  target_e       sel_tgt,
  input  logic          sel_io,
  input  logic [AW-1:0] in_addr,
  input  logic          in_write,
  input  logic [DW-1:0] in_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_ack,
  input  logic [DW-1:0] dev_rdata,
  input  logic          expire,
  output logic          waiting,
  output logic          mem_req,
  output logic          dev_req,
  output logic          dev_io,
  output logic [AW-1:0] tgt_addr,
  output logic          tgt_write,
  output logic [DW-1:0] tgt_wdata,
  output logic          resp_valid,
  output logic          resp_err,
  output logic [DW-1:0] resp_rdata
);
  txn_state_e    state_q;
  logic          sel_ack;
  logic [DW-1:0] sel_rd;

  assign waiting = (state_q == ST_WAIT);
  assign sel_ack = dev_req ? dev_ack : mem_ack;
  assign sel_rd  = dev_req ? dev_rdata : mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mem_req    <= 1'b0;
      dev_req    <= 1'b0;
      dev_io     <= 1'b0;
      tgt_addr   <= '0;
      tgt_write  <= 1'b0;
      tgt_wdata  <= '0;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_WAIT;
            mem_req   <= (sel_tgt == TGT_MEM);
            dev_req   <= (sel_tgt == TGT_DEV);
            dev_io    <= sel_io;
            tgt_addr  <= in_addr;
            tgt_write <= in_write;
            tgt_wdata <= in_wdata;
          end
        end
        ST_WAIT: begin
          if (sel_ack) begin
            state_q    <= ST_IDLE;
            mem_req    <= 1'b0;
            dev_req    <= 1'b0;
            resp_valid <= 1'b1;
            resp_err   <= 1'b0;
            resp_rdata <= sel_rd;
          end else if (expire) begin
            state_q    <= ST_IDLE;
            mem_req    <= 1'b0;
            dev_req    <= 1'b0;
            resp_valid <= 1'b1;
            resp_err   <= 1'b1;
            resp_rdata <= '1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && dev_req));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (!mem_req && !dev_req));

  // R4
  hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (waiting && !sel_ack && !expire) |=>
      (waiting && $stable(tgt_addr) && $stable(mem_req) && $stable(dev_req) && $stable(tgt_wdata)));

  // R7
  ack_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (waiting && sel_ack) |=> (resp_valid && !resp_err && !waiting));

  // R8
  timeout_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (waiting && !sel_ack && expire) |=> (resp_valid && resp_err && (resp_rdata == '1)));

  // R7
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
endmodule

// File: rtl/io_mem_router.sv
module io_mem_router
  import iorouter_pkg::*;
#(
  parameter int AW      = 32,
  parameter int PW      = 16,
  parameter int DW      = 32,
  parameter int NWIN    = 4,
  parameter int TIMEOUT = 16,
  localparam int IDXW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [AW-1:0]   cfg_base,
  input  logic [AW-1:0]   cfg_limit,
  input  logic            cfg_valid,
  input  logic            cfg_lock,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_io,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            resp_valid,
  output logic            resp_err,
  output logic [DW-1:0]   resp_rdata,
  output logic            mem_req,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            dev_req,
  output logic            dev_io,
  output logic            dev_write,
  output logic [AW-1:0]   dev_addr,
  output logic [DW-1:0]   dev_wdata,
  input  logic            dev_ack,
  input  logic [DW-1:0]   dev_rdata
);
  logic          win_hit;
  logic          waiting;
  logic          expire;
  logic          start;
  target_e       sel_tgt;
  logic [AW-1:0] fwd_addr;
  logic [AW-1:0] tgt_addr;
  logic          tgt_write;
  logic [DW-1:0] tgt_wdata;

  io_window_table #(.NWIN(NWIN), .AW(AW)) u_table (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_base  (cfg_base),
    .cfg_limit (cfg_limit),
    .cfg_valid (cfg_valid),
    .cfg_lock  (cfg_lock),
    .look_addr (req_addr),
    .look_hit  (win_hit)
  );

  assign req_ready = !waiting;
  assign start     = req_valid && !waiting;
  assign sel_tgt   = (req_io || win_hit) ? TGT_DEV : TGT_MEM;
  assign fwd_addr  = req_io ? {{(AW-PW){1'b0}}, req_addr[PW-1:0]} : req_addr;

  io_ack_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (waiting),
    .expire (expire)
  );

  io_txn_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sel_tgt    (sel_tgt),
    .sel_io     (req_io),
    .in_addr    (fwd_addr),
    .in_write   (req_write),
    .in_wdata   (req_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .dev_ack    (dev_ack),
    .dev_rdata  (dev_rdata),
    .expire     (expire),
    .waiting    (waiting),
    .mem_req    (mem_req),
    .dev_req    (dev_req),
    .dev_io     (dev_io),
    .tgt_addr   (tgt_addr),
    .tgt_write  (tgt_write),
    .tgt_wdata  (tgt_wdata),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .resp_rdata (resp_rdata)
  );

  assign mem_addr  = tgt_addr;
  assign mem_write = tgt_write;
  assign mem_wdata = tgt_wdata;
  assign dev_addr  = tgt_addr;
  assign dev_write = tgt_write;
  assign dev_wdata = tgt_wdata;

  // R1
  port_route_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_io) |=>
      (dev_req && !mem_req && dev_io && (dev_addr[AW-1:PW] == '0)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !resp_valid) |=> ($stable(mem_addr) || resp_valid));
endmodule

// File: tb/io_mem_router_test.sv
module io_mem_router_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_valid, cfg_lock;
  logic [1:0]  cfg_idx;
  logic [31:0] cfg_base, cfg_limit;
  logic        req_valid, req_ready, req_io, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic        mem_req, mem_write, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        dev_req, dev_io, dev_write, dev_ack;
  logic [31:0] dev_addr, dev_wdata, dev_rdata;

  always #4 clk = ~clk;

  io_mem_router uut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_valid(cfg_valid), .cfg_lock(cfg_lock),
    .req_valid(req_valid), .req_ready(req_ready), .req_io(req_io), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_req(dev_req), .dev_io(dev_io), .dev_write(dev_write), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_ack(dev_ack), .dev_rdata(dev_rdata)
  );

  int vecs = 0;
  int errs = 0;
  bit done = 0;
  logic [31:0] mb [4];
  logic [31:0] ml [4];
  bit          mv [4];
  bit          locked_m = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_dev(bit io, logic [31:0] a);
    if (io) return 1'b1;
    for (int i = 0; i < 4; i++)
      if (mv[i] && a >= mb[i] && a <= ml[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic cfg_write(int idx, logic [31:0] b, logic [31:0] l, bit v);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx[1:0]; cfg_base = b; cfg_limit = l; cfg_valid = v;
    @(negedge clk);
    cfg_we = 0;
    if (!locked_m) begin mb[idx] = b; ml[idx] = l; mv[idx] = v; end
  endtask

  task automatic set_lock();
    @(negedge clk);
    cfg_lock = 1;
    @(negedge clk);
    cfg_lock = 0;
    locked_m = 1;
  endtask

  // who: 0 none, 1 memory acks, 2 device acks; d: ack on edge d after acceptance
  task automatic txn(bit io, logic [31:0] a, bit wr, int who, int d, string req);
    bit ed;
    bit correct;
    int fin_k;
    bit ok_end;
    logic [31:0] eaddr, wd, rd;
    ed = exp_dev(io, a);
    eaddr = io ? {16'h0, a[15:0]} : a;
    wd = a ^ 32'h5A5A_0000;
    rd = 32'hC0DE_0000 ^ {a[15:0], 16'h0} ^ d;
    correct = (who == 1 && !ed) || (who == 2 && ed);
    ok_end = correct && d >= 1 && d <= 16;
    fin_k = ok_end ? d : 16;
    @(negedge clk);
    chk("R9", "ready before request", {31'h0, req_ready}, 32'h1);
    req_valid = 1; req_io = io; req_addr = a; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(req, "target select {mem,dev}", {30'h0, mem_req, dev_req}, ed ? 32'h1 : 32'h2);
    chk(req, "target address", ed ? dev_addr : mem_addr, eaddr);
    chk("R4", "write flag/data", ed ? {dev_wdata[31:1], dev_write} : {mem_wdata[31:1], mem_write},
        {wd[31:1], wr});
    if (ed) chk("R1", "space flag to devices", {31'h0, dev_io}, {31'h0, io});
    chk("R9", "busy ready", {31'h0, req_ready}, 32'h0);
    for (int k = 1; k <= fin_k; k++) begin
      if (k == d && who == 1) begin mem_ack = 1; mem_rdata = rd; end
      if (k == d && who == 2) begin dev_ack = 1; dev_rdata = rd; end
      @(negedge clk);
      mem_ack = 0; dev_ack = 0;
      mem_rdata = 32'h0; dev_rdata = 32'h0;
      if (k < fin_k) begin
        chk(ok_end ? "R7" : "R8", "no early response", {31'h0, resp_valid}, 32'h0);
      end else begin
        chk(ok_end ? "R7" : "R8", "response valid", {31'h0, resp_valid}, 32'h1);
        chk(ok_end ? "R7" : "R8", "response error", {31'h0, resp_err}, {31'h0, !ok_end});
        chk(ok_end ? "R7" : "R8", "response data", resp_rdata, ok_end ? rd : 32'hFFFF_FFFF);
        chk("R4", "targets released", {30'h0, mem_req, dev_req}, 32'h0);
      end
    end
    @(negedge clk);
    chk("R7", "response is one cycle", {31'h0, resp_valid}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] pts [8];
    rst = 1; cfg_we = 0; cfg_idx = 0; cfg_base = 0; cfg_limit = 0; cfg_valid = 0; cfg_lock = 0;
    req_valid = 0; req_io = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    mem_ack = 0; mem_rdata = 0; dev_ack = 0; dev_rdata = 0;
    for (int i = 0; i < 4; i++) begin mb[i] = 0; ml[i] = 0; mv[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R9", "reset ready", {31'h0, req_ready}, 32'h1);
    chk("R4", "reset targets idle", {30'h0, mem_req, dev_req}, 32'h0);
    chk("R7", "reset no response", {31'h0, resp_valid}, 32'h0);

    // R6: empty table, every memory-space address goes to memory
    for (int j = 0; j < 8; j++) txn(0, 32'h0000_1000 * j + 32'h000A_0000 * (j % 2), j % 2, 1, 1, "R6");

    // Table: a DOS-style hole, a small window, an inverted window, an invalid window
    cfg_write(0, 32'h000A_0000, 32'h000F_FFFF, 1);
    cfg_write(1, 32'h0000_1000, 32'h0000_1FFF, 1);
    cfg_write(2, 32'h0000_5000, 32'h0000_4000, 1);
    cfg_write(3, 32'h0000_8000, 32'h0000_8FFF, 0);

    // R2 / R3 / R6: boundary sweep around every entry
    for (int e = 0; e < 4; e++) begin
      pts[0] = mb[e] - 1; pts[1] = mb[e]; pts[2] = mb[e] + 1; pts[3] = (mb[e] + ml[e]) >> 1;
      pts[4] = ml[e] - 1; pts[5] = ml[e]; pts[6] = ml[e] + 1; pts[7] = ml[e] + 32'h100;
      for (int p = 0; p < 8; p++)
        txn(0, pts[p], p % 2, exp_dev(0, pts[p]) ? 2 : 1, 1 + p % 3,
            exp_dev(0, pts[p]) ? "R2" : (e >= 2 ? "R6" : "R3"));
    end

    // R1: port space always goes to devices, upper bits dropped
    for (int j = 0; j < 16; j++) txn(1, 32'h1234_5678 * j + 32'h000A_1000, j % 2, 2, 2, "R1");

    // R7 / R8: ack delay sweep for each target, right and wrong acknowledger
    for (int d = 1; d <= 18; d++) begin
      txn(0, 32'h0000_0040, 0, 1, d, "R7");
      txn(0, 32'h0000_1800, 0, 2, d, "R7");
      txn(0, 32'h0000_0044, 1, 2, d, "R8");
      txn(1, 32'h0000_0060, 0, 1, d, "R8");
    end

    // R5: writes work before the lock, are ignored after it
    cfg_write(3, 32'h0000_8000, 32'h0000_8FFF, 1);
    txn(0, 32'h0000_8800, 0, 2, 1, "R5");
    set_lock();
    cfg_write(3, 32'h0000_8000, 32'h0000_8FFF, 0);
    cfg_write(1, 32'h0000_0000, 32'hFFFF_FFFF, 1);
    txn(0, 32'h0000_8800, 0, 2, 1, "R5");
    txn(0, 32'h0000_2000, 0, 1, 1, "R5");
    txn(0, 32'h0000_1000, 0, 2, 1, "R5");

    // R9: a request presented while busy is not accepted
    @(negedge clk);
    req_valid = 1; req_io = 0; req_addr = 32'h0000_0100; req_write = 0; req_wdata = 0;
    @(negedge clk);
    req_valid = 0;
    chk("R9", "first request to memory", {30'h0, mem_req, dev_req}, 32'h2);
    @(negedge clk);
    req_valid = 1; req_io = 1; req_addr = 32'h0000_0300;
    @(negedge clk);
    chk("R9", "ready low while busy", {31'h0, req_ready}, 32'h0);
    chk("R9", "address unchanged while busy", mem_addr, 32'h0000_0100);
    req_valid = 0;
    mem_ack = 1; mem_rdata = 32'h0000_BEEF;
    @(negedge clk);
    mem_ack = 0;
    chk("R9", "busy-case response", resp_rdata, 32'h0000_BEEF);
    @(negedge clk);
    chk("R9", "ignored request not started", {30'h0, mem_req, dev_req}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule